// File: doc/BRIEF.md
# Receive Word Queue With Head Status

This block sits behind a serial receiver and holds the words the receiver has assembled. Each stored entry keeps three things: a data word, the 3-bit station address that arrived in the same frame, and the parity bit that was received. The oldest entry, the head, is always shown on the data port, and its status is shown on a status port. A read strobe takes the head away, and the next stored entry then moves up to the head.

The status port also carries a message-delimiter flag, and what that flag means depends on the protocol mode. In the addressed-station family of modes, the flag marks a head word whose station address is all ones, which is the end-of-message address. In the two coax-terminal modes, the flag marks a head word whose odd parity, computed locally over the data, differs from the parity bit that was received. Software polls the data-available flag and the status, and reads data bit 0 to tell whether a command frame is single-frame. A synchronous receiver clear empties the queue.

Top module: `rxq_status_fifo`

## Requirements
- R1: Status bits [2:0] show the station address of the head entry while data-available is high, and read 3'b000 while the queue is empty.
- R2: A read strobe with the queue non-empty removes the head at the clock edge. After that edge, rd_data and the status show the next entry in arrival order. With no read, the head data and address stay unchanged. rd_data presents the stored word unchanged, so bit 0 is the first data bit after sync.
- R3: When mode[1] is 1 (the addressed-station modes), the delimiter flag is 1 exactly when the head address is 3'b111.
- R4: When mode[1] is 0 (the coax-terminal modes), the delimiter flag is 1 exactly when the local odd parity of the head data differs from the head's stored received parity bit. The local odd parity is 1 when the data holds an even number of ones.
- R5: The delimiter flag appears both on the delim port and on status bit 3, and it is 0 while the queue is empty.
- R6: data_avail and status bit 5 are 1 whenever the queue holds at least one entry. The queue holds up to DEPTH entries.
- R7: A read strobe while the queue is empty changes nothing.
- R8: A write while the queue is full, with no read in the same cycle, is dropped and sets status bit 4 (overrun). The overrun bit stays set until a clear. A write and a read in the same cycle while full are both performed.
- R9: A reset or rcv_clr empties the queue and clears overrun. Status bits [7:6] always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rcv_clr | input | 1 | Synchronous receiver clear |
| mode | input | 2 | Protocol mode; bit 1 selects the addressed-station family |
| wr_en | input | 1 | Push strobe |
| wr_data | input | DW | Received data word |
| wr_addr | input | 3 | Received station address |
| wr_par | input | 1 | Received parity bit |
| rd_en | input | 1 | Pop strobe (data port read) |
| rd_data | output | DW | Head data word |
| rd_stat | output | 8 | Head status: [2:0] address, [3] delimiter, [4] overrun, [5] data-available |
| data_avail | output | 1 | Queue not empty |
| delim | output | 1 | Delimiter flag of the head |

## Verification
The bench goes after these corner cases:
- A read and a write in the same cycle while the queue is full. A design that treats this as an overrun would lose the new word.
- Reads while the queue is empty. A design that moves its pointers on such a read would later show stale or duplicated heads.
- Switching the mode while a word sits at the head. A design that latched the delimiter at write time, rather than decoding it from the live mode, would show the wrong flag.
- An empty queue that still holds old entries in storage. A design that did not gate the address and delimiter with data-available would leak old values onto the status port.

// File: rtl/rxq_status_fifo.sv
module rxq_status_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rcv_clr,
  input  logic [1:0]    mode,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic [2:0]    wr_addr,
  input  logic          wr_par,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic [7:0]    rd_stat,
  output logic          data_avail,
  output logic          delim
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int EW = DW + 4;
  localparam int CW = $clog2(DEPTH + 1);

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          ovr;

  wire full  = (cnt == CW'(DEPTH));
  wire do_rd = rd_en && (cnt != '0);
  wire do_wr = wr_en && (!full || do_rd);

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; cnt <= '0; ovr <= 1'b0;
    end else if (rcv_clr) begin
      wptr <= '0; rptr <= '0; cnt <= '0; ovr <= 1'b0;
    end else begin
      if (do_wr) wptr <= nxt(wptr);
      if (do_rd) rptr <= nxt(rptr);
      if (do_wr && !do_rd) cnt <= cnt + 1'b1;
      else if (do_rd && !do_wr) cnt <= cnt - 1'b1;
      if (wr_en && full && !do_rd) ovr <= 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (do_wr && rst_n && !rcv_clr) mem[wptr] <= {wr_par, wr_addr, wr_data};

  wire [EW-1:0] head = mem[rptr];
  wire [DW-1:0] hdat = head[DW-1:0];
  wire [2:0]    hadr = head[DW+2:DW];
  wire          hpar = head[DW+3];

  assign data_avail = (cnt != '0);
  assign rd_data    = data_avail ? hdat : '0;
  assign delim      = data_avail && (mode[1] ? (hadr == 3'b111) : ((~^hdat) != hpar));
  assign rd_stat    = {2'b00, data_avail, ovr, delim, data_avail ? hadr : 3'b000};

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  assert_empty_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_avail && rd_en && !wr_en && !rcv_clr) |=> !data_avail);
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !rcv_clr) |=> ovr);
  assert_addr_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !data_avail |-> (rd_stat[2:0] == 3'b000 && !delim));
  assert_head_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (data_avail && !rd_en && !rcv_clr) |=> ($stable(rd_data) && $stable(rd_stat[2:0])));
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rcv_clr |=> (!data_avail && !rd_stat[4]));
  assert_flag_mirror_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat[3] == delim);
endmodule

// File: tb/sim_rxq_status_fifo.sv
module sim_rxq_status_fifo;
  localparam int CLK = 10;
  localparam int DW = 8, DEPTH = 4;

  logic clk = 0, rst_n = 0, rcv_clr = 0, wr_en = 0, wr_par = 0, rd_en = 0;
  logic [1:0] mode = 2'b10;
  logic [DW-1:0] wr_data = 0;
  logic [2:0] wr_addr = 0;
  logic [DW-1:0] rd_data;
  logic [7:0] rd_stat;
  logic data_avail, delim;

  int tests = 0, fails = 0;
  logic [DW+3:0] q[$];
  bit m_ovr = 0;

  rxq_status_fifo #(.DW(DW), .DEPTH(DEPTH)) u0 (.*);

  always #(CLK/2) clk = ~clk;

  initial begin
    #(CLK*200000);
    fails++; tests++;
    $display("FAIL watchdog: run did not end (actual hung, expected done)");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_delim(logic [DW+3:0] e, logic [1:0] m);
    int ones = 0;
    for (int i = 0; i < DW; i++) ones += e[i];
    if (m[1]) return e[DW+2:DW] == 3'b111;
    return ((ones % 2) == 0) != e[DW+3];
  endfunction

  task automatic compare();
    bit av = q.size() > 0;
    logic [DW+3:0] h = av ? q[0] : '0;
    bit dl = av ? exp_delim(h, mode) : 0;
    chk("R6 data_avail", data_avail, av);
    chk("R6 stat5", rd_stat[5], av);
    chk("R1 addr", rd_stat[2:0], h[DW+2:DW]);
    chk("R2 data", rd_data, h[DW-1:0]);
    chk(mode[1] ? "R3 delim" : "R4 delim", delim, dl);
    chk("R5 stat3", rd_stat[3], dl);
    chk("R8 overrun", rd_stat[4], m_ovr);
    chk("R9 stat76", rd_stat[7:6], 0);
  endtask

  task automatic step(bit we, logic [DW-1:0] d, logic [2:0] a, bit p, bit re, bit cl, logic [1:0] m);
    bit doread, full;
    wr_en = we; wr_data = d; wr_addr = a; wr_par = p; rd_en = re; rcv_clr = cl; mode = m;
    @(posedge clk);
    if (cl) begin q.delete(); m_ovr = 0; end
    else begin
      doread = re && q.size() > 0;
      full = q.size() == DEPTH;
      if (doread) void'(q.pop_front());
      if (we) begin
        if (full && !doread) m_ovr = 1;
        else q.push_back({p, a, d});
      end
    end
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (2) @(negedge clk);
    compare();                                   // R9 reset state
    rst_n = 1;
    @(negedge clk); compare();
    step(0, 0, 0, 0, 1, 0, 2'b10);               // R7 empty read
    for (int i = 0; i < DEPTH + 2; i++)          // R8 fill past full
      step(1, DW'(8'h31 + i), 3'(i + 5), 0, 0, 0, 2'b10);
    step(1, 8'hAA, 3'd7, 1, 1, 0, 2'b10);        // R8 full write+read together
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, 2'(i)); // R3/R4 mode switch, R2 hold
    step(0, 0, 0, 0, 0, 1, 2'b00);               // R9 clear
    step(1, 8'h01, 3'd1, 0, 0, 0, 2'b00);        // R4 single-frame bit0, parity match
    step(1, 8'h03, 3'd2, 0, 0, 0, 2'b00);        // R4 mismatch
    step(0, 0, 0, 0, 1, 0, 2'b01);               // R2 pop
    for (int i = 0; i < 3000; i++)
      step($urandom_range(0, 1), DW'($urandom), 3'($urandom), 1'($urandom),
           $urandom_range(0, 2) == 0, $urandom_range(0, 60) == 0, 2'($urandom));
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule